// File: doc/BRIEF.md
# Serial Signed Fractional Multiplier

This block multiplies two two's-complement fractions of W bits (20 by default). Each operand carries its sign in the top bit and W-1 fraction bits below it. The multiplicand is held in its own register. The multiplier register also serves as the low half of the product: as each multiplier bit is used, it leaves the register and a product bit takes its place. The high half of the product builds up in an accumulator. A negative multiplier is handled once, before the first step, by negating both operands. After that, every step adds the multiplicand or only shifts.

A run takes 2W+1 steps: one correction step, W add steps, W-1 shift steps and one final alignment step. The alignment step puts the binary point of the double-length result between the two top bits of the high word. While the block is idle it has three more functions. It can shift the whole double-length product left by one place. It shows a rounded single-word result at all times. It also shows the low word read out one place early, so that a double-length value can be stored with a sign bit at the top of each word.

Top module: `sfm_top`

## Requirements
- R1: `load_mcand` captures `mcand_in` and `load_mplier` captures `mplier_in`, but only on an edge where the block is idle and `start` is low. On any other edge the loads are ignored, and a multiply in progress uses the operands it started with.
- R2: When `done` rises, {`prod_hi`,`prod_lo`} equals the signed product a*b shifted left by one place, taken modulo 2^(2W). Here a and b are the operands as two's-complement integers. This holds for all four sign combinations, and the binary point lies between `prod_hi[W-1]` and `prod_hi[W-2]`.
- R3: The most negative operand times itself wraps: `prod_hi` = 1 followed by W-1 zeros, and `prod_lo` = 0.
- R4: After a multiply, `prod_lo[0]` is 0.
- R5: `start` is accepted on an edge where the block is idle, and it clears `done`. `busy` is high after that edge. On the 2W+1-th edge after the accepting edge, `busy` falls and `done` rises, and `done` stays high until the next accepted `start`.
- R6: `start` is ignored while `busy` is high. A pulse during a run changes neither when the run finishes nor its result.
- R7: `prod_round` equals (`prod_hi` + `prod_lo[W-1]`) modulo 2^W.
- R8: `prod_lo_early` equals {`prod_hi[W-1]`, `prod_lo[W-1:1]`}.
- R9: When `shl` is 1 on an idle edge with `start` and `load_mplier` low, the double-length product moves one place left: `prod_lo[W-1]` enters `prod_hi[0]`, a 0 enters `prod_lo[0]`, and the old `prod_hi[W-1]` is lost. With `shl` low the product is unchanged. A `shl` pulse while `busy` is high has no effect.
- R10: While reset is asserted, `busy`, `done`, `prod_hi` and `prod_lo` are 0.
- R11: On an idle edge, `start` takes priority over `load_mplier`, and `load_mplier` takes priority over `shl`. A `start` therefore uses the current contents of the multiplier register, which after a multiply is the old low product word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| mcand_in | input | W | Multiplicand value |
| load_mcand | input | 1 | Capture `mcand_in` |
| mplier_in | input | W | Multiplier value |
| load_mplier | input | 1 | Capture `mplier_in` into the multiplier / low-product register |
| start | input | 1 | Begin a multiply |
| shl | input | 1 | Shift the double-length product left one place |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Result valid |
| prod_hi | output | W | High product word |
| prod_lo | output | W | Low product word |
| prod_round | output | W | High word rounded by the top bit of the low word |
| prod_lo_early | output | W | Low word read one place early, topped by the sign |

## Verification
Some behaviours hold on every cycle and are checked by assertions. `busy` and `done` are never high together. A run, once begun, advances one step per edge and cannot restart. The alignment step always leaves the low product bit clear. A left shift moves exactly one bit across the word boundary. The multiplicand register holds still during the arithmetic steps. The arithmetic results can only be shown by the bench. It sweeps every pair drawn from a set of corner operands: zero, plus and minus one least significant bit, both extremes, and plus and minus one half. It then runs pseudo-random operand pairs. For each run it checks the exact finishing edge, both product words, the rounded output and the early-read output. Separate scenarios cover loads and starts during a run, the priority order on an idle edge, and left shifts.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  // Datapath operation selected by the sequencer for one edge.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_CORR  = 3'd1,
    OP_ADD   = 3'd2,
    OP_SHR   = 3'd3,
    OP_ALIGN = 3'd4,
    OP_LDB   = 3'd5,
    OP_SHL   = 3'd6
  } sfm_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sfm_state_e;

endpackage

// File: rtl/sfm_seq.sv
module sfm_seq
  import sfm_pkg::*;
#(
  parameter int W = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    load_mplier,
  input  logic    shl,
  output sfm_op_e op,
  output logic    ld_c_ok,
  output logic    busy,
  output logic    done
);

  localparam int STEPS = 2 * W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  sfm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    cnt_en  = 1'b0;
    op      = OP_IDLE;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          done_d  = 1'b0;
        end else if (load_mplier) begin
          op = OP_LDB;
        end else if (shl) begin
          op = OP_SHL;
        end
      end
      ST_RUN: begin
        if (cnt_q == '0)        op = OP_CORR;
        else if (cnt_q == LAST) op = OP_ALIGN;
        else if (cnt_q[0])      op = OP_ADD;
        else                    op = OP_SHR;
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign ld_c_ok = (state_q == ST_IDLE) && !start;

  // R5: a finished result and a run in progress never coexist
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q));

  // R5: done only rises out of a run
  a_r5_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q == ST_RUN));

  // R6: once running, each edge advances one step whatever start does
  a_r6_run_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sfm_path.sv
module sfm_path
  import sfm_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sfm_op_e      op,
  input  logic         ld_c,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam int MW = W + 1;  // corrected multiplicand
  localparam int AW = W + 2;  // accumulator with headroom

  logic [W-1:0]  c_q;
  logic [MW-1:0] mc_q, mc_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  lo_q, lo_d;
  logic          mc_en, acc_en, lo_en;
  logic [MW-1:0] c_ext;
  logic          b_neg;

  assign c_ext = {c_q[W-1], c_q};
  assign b_neg = lo_q[W-1];

  always_comb begin
    mc_d   = mc_q;
    acc_d  = acc_q;
    lo_d   = lo_q;
    mc_en  = 1'b0;
    acc_en = 1'b0;
    lo_en  = 1'b0;
    unique case (op)
      OP_CORR: begin
        // a*b == (-a)*(-b): make the multiplier non-negative up front
        mc_d   = b_neg ? (~c_ext + 1'b1) : c_ext;
        lo_d   = b_neg ? (~lo_q + 1'b1) : lo_q;
        acc_d  = '0;
        mc_en  = 1'b1;
        acc_en = 1'b1;
        lo_en  = 1'b1;
      end
      OP_ADD: begin
        acc_d  = acc_q + {mc_q[MW-1], mc_q};
        acc_en = lo_q[0];
      end
      OP_SHR: begin
        acc_d  = {acc_q[AW-1], acc_q[AW-1:1]};
        lo_d   = {acc_q[0], lo_q[W-1:1]};
        acc_en = 1'b1;
        lo_en  = 1'b1;
      end
      OP_ALIGN: begin
        // drop the spent multiplier bit, leaving the product doubled
        lo_d  = {lo_q[W-1:1], 1'b0};
        lo_en = 1'b1;
      end
      OP_LDB: begin
        lo_d  = mplier_in;
        lo_en = 1'b1;
      end
      OP_SHL: begin
        acc_d  = {acc_q[AW-2:0], lo_q[W-1]};
        lo_d   = {lo_q[W-2:0], 1'b0};
        acc_en = 1'b1;
        lo_en  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '0;
    else if (ld_c) c_q <= mcand_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc_q <= '0;
    else if (mc_en) mc_q <= mc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign hi = acc_q[W-1:0];
  assign lo = lo_q;

  // R4: alignment always leaves the lowest product bit clear
  a_r4_align_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ALIGN) |=> (lo_q[0] == 1'b0));

  // R9: a left shift moves exactly one bit across the word boundary
  a_r9_shl_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL) |=> (acc_q[0] == $past(lo_q[W-1]) &&
                        acc_q[W-1:1] == $past(acc_q[W-2:0]) &&
                        lo_q == {$past(lo_q[W-2:0]), 1'b0}));

  // R1: the multiplicand holds still across arithmetic steps
  a_r1_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD || op == OP_SHR) |=> $stable(c_q));

endmodule

// File: rtl/sfm_fmt.sv
module sfm_fmt #(
  parameter int W = 20
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] rnd,
  output logic [W-1:0] lo_early
);

  // R7: fold the top bit of the low word into the bottom of the high word
  assign rnd = hi + W'(lo[W-1]);

  // R8: low word one place early, sign copied into the freed top bit
  assign lo_early = {hi[W-1], lo[W-1:1]};

endmodule

// File: rtl/sfm_top.sv
module sfm_top
  import sfm_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mcand_in,
  input  logic         load_mcand,
  input  logic [W-1:0] mplier_in,
  input  logic         load_mplier,
  input  logic         start,
  input  logic         shl,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_round,
  output logic [W-1:0] prod_lo_early
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  sfm_op_e    op;
  logic       ld_c_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sfm_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (start),
    .load_mplier (load_mplier),
    .shl         (shl),
    .op          (op),
    .ld_c_ok     (ld_c_ok),
    .busy        (busy),
    .done        (done)
  );

  sfm_path #(.W(W)) u_path (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .op        (op),
    .ld_c      (ld_c_ok && load_mcand),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .hi        (prod_hi),
    .lo        (prod_lo)
  );

  sfm_fmt #(.W(W)) u_fmt (
    .hi       (prod_hi),
    .lo       (prod_lo),
    .rnd      (prod_round),
    .lo_early (prod_lo_early)
  );

  // R4: every completed run ends with a clear lowest product bit
  a_r4_done_lsb: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(busy) |-> (prod_lo[0] == 1'b0));

  // R9: with nothing requested on an idle edge the product holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && !start && !load_mplier && !shl) |=>
      ($stable(prod_hi) && $stable(prod_lo)));

endmodule

// File: tb/sfm_top_bench.sv
module sfm_top_bench;

  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] mcand_in, mplier_in;
  logic         load_mcand, load_mplier, start, shl;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo, prod_round, prod_lo_early;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  all_done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;  // 250 MHz

  sfm_top #(.W(W)) u_sfm_top (
    .clk (clk), .rst_n (rst_n),
    .mcand_in (mcand_in), .load_mcand (load_mcand),
    .mplier_in (mplier_in), .load_mplier (load_mplier),
    .start (start), .shl (shl),
    .busy (busy), .done (done),
    .prod_hi (prod_hi), .prod_lo (prod_lo),
    .prod_round (prod_round), .prod_lo_early (prod_lo_early)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] exp_word(input logic [W-1:0] a, input logic [W-1:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return (2*W)'(p * 2);
  endfunction

  task automatic check_outputs(input string tag, input logic [2*W-1:0] w);
    logic [W-1:0] eh, el;
    eh = w[2*W-1:W];
    el = w[W-1:0];
    chk({tag, " R2 hi"}, 64'(prod_hi), 64'(eh));
    chk({tag, " R2 lo"}, 64'(prod_lo), 64'(el));
    chk({tag, " R4 lsb"}, 64'(prod_lo[0]), 64'd0);
    chk({tag, " R7 round"}, 64'(prod_round), 64'(W'(eh + W'(el[W-1]))));
    chk({tag, " R8 early"}, 64'(prod_lo_early), 64'({eh[W-1], el[W-1:1]}));
  endtask

  // loads both operands, starts, checks the finishing edge
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit timing);
    @(negedge clk);
    mcand_in = a; mplier_in = b; load_mcand = 1'b1; load_mplier = 1'b1;
    @(negedge clk);
    load_mcand = 1'b0; load_mplier = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (timing) begin
      chk("R5 busy after accept", 64'(busy), 64'd1);
      chk("R5 done cleared", 64'(done), 64'd0);
    end
    repeat (2*W) @(negedge clk);
    if (timing) chk("R5 done low one edge early", 64'(done), 64'd0);
    @(negedge clk);
    chk("R5 done at 2W+1", 64'(done), 64'd1);
    chk("R5 busy fell", 64'(busy), 64'd0);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  initial begin
    logic [W-1:0] corners [9];
    logic [2*W-1:0] w;
    logic [W-1:0] ra, rb, prev_lo, prev_hi;
    corners[0] = 20'h00000; corners[1] = 20'h00001; corners[2] = 20'hFFFFF;
    corners[3] = 20'h7FFFF; corners[4] = 20'h80000; corners[5] = 20'h40000;
    corners[6] = 20'hC0000; corners[7] = 20'h12345; corners[8] = 20'hEDCBB;

    rst_n = 1'b0; mcand_in = '0; mplier_in = '0;
    load_mcand = 1'b0; load_mplier = 1'b0; start = 1'b0; shl = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 hi", 64'(prod_hi), 64'd0);
    chk("R10 lo", 64'(prod_lo), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: corner sweep over all sign combinations
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        run_mul(corners[i], corners[j], (i == j));
        check_outputs("corner", exp_word(corners[i], corners[j]));
      end
    end

    // R3: most negative squared wraps
    run_mul(20'h80000, 20'h80000, 1'b1);
    chk("R3 hi wrap", 64'(prod_hi), 64'h80000);
    chk("R3 lo wrap", 64'(prod_lo), 64'h0);

    // R2: pseudo-random operands
    for (int k = 0; k < 150; k++) begin
      rng = next_rng(rng); ra = rng[W-1:0];
      rng = next_rng(rng); rb = rng[W-1:0];
      run_mul(ra, rb, 1'b0);
      check_outputs("random", exp_word(ra, rb));
    end

    // R1, R6, R9: loads, start and shl during a run are ignored
    @(negedge clk);
    mcand_in = 20'h2B3C4; mplier_in = 20'hA1B2C; load_mcand = 1'b1; load_mplier = 1'b1;
    @(negedge clk);
    load_mcand = 1'b0; load_mplier = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; shl = 1'b1; load_mcand = 1'b1; load_mplier = 1'b1;
    mcand_in = 20'h55555; mplier_in = 20'h33333;
    @(negedge clk);
    start = 1'b0; shl = 1'b0; load_mcand = 1'b0; load_mplier = 1'b0;
    repeat (2*W - 11) @(negedge clk);
    chk("R6 no early finish", 64'(done), 64'd0);
    @(negedge clk);
    chk("R6 done unchanged", 64'(done), 64'd1);
    check_outputs("R1 R6 R9 busy pulses ignored", exp_word(20'h2B3C4, 20'hA1B2C));

    // R9: left shift of the whole product, and hold without shl
    w = exp_word(20'h2B3C4, 20'hA1B2C);
    @(negedge clk); shl = 1'b1;
    @(negedge clk); shl = 1'b0;
    w = w << 1;
    chk("R9 shl hi", 64'(prod_hi), 64'(w[2*W-1:W]));
    chk("R9 shl lo", 64'(prod_lo), 64'(w[W-1:0]));
    repeat (3) @(negedge clk);
    chk("R9 hold hi", 64'(prod_hi), 64'(w[2*W-1:W]));
    chk("R9 hold lo", 64'(prod_lo), 64'(w[W-1:0]));
    @(negedge clk); shl = 1'b1;
    @(negedge clk); shl = 1'b0;
    w = w << 1;
    chk("R9 second shl hi", 64'(prod_hi), 64'(w[2*W-1:W]));
    chk("R9 second shl lo", 64'(prod_lo), 64'(w[W-1:0]));

    // R11: start beats load_mplier and shl; multiplier is the old low word
    prev_lo = prod_lo;
    start = 1'b1; load_mplier = 1'b1; shl = 1'b1; mplier_in = 20'h0F0F0;
    @(negedge clk);
    start = 1'b0; load_mplier = 1'b0; shl = 1'b0;
    chk("R11 start accepted", 64'(busy), 64'd1);
    repeat (2*W + 1) @(negedge clk);
    chk("R11 done", 64'(done), 64'd1);
    check_outputs("R11 start priority", exp_word(20'h2B3C4, prev_lo));

    // R11: load_mplier beats shl
    prev_hi = prod_hi;
    load_mplier = 1'b1; shl = 1'b1; mplier_in = 20'h6A5A5;
    @(negedge clk);
    load_mplier = 1'b0; shl = 1'b0;
    chk("R11 load over shl lo", 64'(prod_lo), 64'h6A5A5);
    chk("R11 load over shl hi", 64'(prod_hi), 64'(prev_hi));

    all_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule